// File: doc/BRIEF.md
# Synchronized Clock Gate and Divider

This block distributes one of two candidate clocks to a set of clock outputs. A select line chooses the source. An enable input, which may change at any moment with no relation to either clock, is carried into the selected clock domain on falling edges. The gating therefore only opens or closes while the clock is low. Every pulse the block emits is then either complete or absent.

The block has two banks of outputs, and every output comes as a true signal with a complemented partner. The full-rate bank reproduces the selected clock. The half-rate bank toggles on each enabled rising edge, so it runs at half the frequency with an equal high and low time. An active-high master reset empties the divider and the enable synchronizer, and parks every output. After reset is released, or after a disable and re-enable, the first enabled rising edge drives both banks high together. This gives the two banks a fixed phase relationship.

Top module: `clkgate_div_fanout`

## Requirements
- R1: With `sel` low the outputs are driven from `clk_a`; with `sel` high they are driven from `clk_b` (the full-rate output period equals the period of the selected clock).
- R2: While the synchronized enable is high, every full-rate true output copies the selected clock. While it is low, every true output (both banks) is low and every complement output is high.
- R3: A change on `en` reaches the outputs only after the selected clock has produced a rising edge and then a falling edge. It is taken in on the second falling edge after the change and shows from the rising edge that follows: if `en` changes while the clock is high, the next rising edge still gives the old behaviour and the one after gives the new behaviour.
- R4: However `en` is timed against the clock, no high or low time on any output is shorter than half a period of the selected clock.
- R5: While `mr` is high, all true outputs are low and all complement outputs are high, whatever `en` and `sel` do. Reset acts at once, without waiting for a clock edge.
- R6: Each complement output is at all times the bitwise inverse of its true output.
- R7: While enabled, each half-rate true output toggles on every rising edge of the selected clock. It makes one rising edge for every two rising edges of the full-rate outputs, and it stays high for one full input period.
- R8: After `mr` is released, or after a disable followed by a re-enable, the first enabled rising edge of the selected clock drives the half-rate outputs high together with the full-rate outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Candidate clock chosen when `sel` is low |
| clk_b | input | 1 | Candidate clock chosen when `sel` is high |
| sel | input | 1 | Source select; change it only while disabled or in reset |
| en | input | 1 | Asynchronous output enable, active high |
| mr | input | 1 | Asynchronous master reset, active high |
| q_full | output | N_FULL | Full-rate true clock outputs |
| qn_full | output | N_FULL | Full-rate complement outputs |
| q_half | output | N_HALF | Half-rate true clock outputs |
| qn_half | output | N_HALF | Half-rate complement outputs |

## Verification
A synchronizer that is one stage short, or one clocked on the wrong edge, shows up as a response to `en` that comes one rising edge too early. If it samples on rising edges, the gate closes while the clock is high, and a shortened high pulse appears on the full-rate outputs in the first cycle after an enable change. A divider that keeps its phase while disabled, or that is not cleared by reset, leaves the half-rate outputs low on the first enabled edge instead of high. The bench sees this right after release or re-enable. A divider that toggles on the wrong condition gives a wrong rising-edge count within a forty-cycle window. To catch these faults, the bench sweeps the enable edge across ten phase offsets of both source clocks and measures every output edge-to-edge interval against half the selected period.

// File: rtl/cgd_pkg.sv
package cgd_pkg;

    // Source choice carried on the select line
    typedef enum logic {
        SRC_PRIMARY   = 1'b0,
        SRC_ALTERNATE = 1'b1
    } src_sel_e;

    // Fewer stages than this would not give the rise-then-fall ordering
    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/cgd_src_mux.sv
module cgd_src_mux
    import cgd_pkg::*;
(
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel,
    output logic clk_o
);

    src_sel_e choice;

    always_comb begin
        choice = src_sel_e'(sel);
        case (choice)
            SRC_PRIMARY:   clk_o = clk_a;
            SRC_ALTERNATE: clk_o = clk_b;
            default:       clk_o = clk_a;
        endcase
    end

endmodule

// File: rtl/cgd_en_sync.sv
module cgd_en_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic mr,
    input  logic en_async,
    output logic en_sync
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = en_async;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    // Falling-edge capture: the qualified enable only moves while clk is low
    always_ff @(negedge clk or posedge mr) begin
        if (mr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_sync = st_q.chain[LAST];

endmodule

// File: rtl/cgd_full_bank.sv
module cgd_full_bank #(
    parameter int unsigned N_OUT = 2
) (
    input  logic             clk,
    input  logic             en_sync,
    output logic [N_OUT-1:0] q,
    output logic [N_OUT-1:0] qn
);

    logic gated;

    // en_sync changes only on falling edges, so this AND never clips a high phase
    assign gated = clk & en_sync;

    for (genvar g = 0; g < int'(N_OUT); g++) begin : g_out
        assign q[g]  = gated;
        assign qn[g] = ~gated;
    end

endmodule

// File: rtl/cgd_half_bank.sv
module cgd_half_bank #(
    parameter int unsigned N_OUT = 2
) (
    input  logic             clk,
    input  logic             mr,
    input  logic             en_sync,
    output logic [N_OUT-1:0] q,
    output logic [N_OUT-1:0] qn
);

    typedef struct packed {
        logic phase;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    level;

    always_comb begin
        st_d = st_q;
        // Toggle while enabled; park at zero while disabled so restart phase is fixed
        if (en_sync) begin
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.phase & en_sync;

    for (genvar g = 0; g < int'(N_OUT); g++) begin : g_out
        assign q[g]  = level;
        assign qn[g] = ~level;
    end

endmodule

// File: rtl/clkgate_div_fanout.sv
module clkgate_div_fanout #(
    parameter int unsigned N_FULL      = 2,
    parameter int unsigned N_HALF      = 2,
    parameter int unsigned SYNC_STAGES = cgd_pkg::MIN_SYNC_STAGES
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              sel,
    input  logic              en,
    input  logic              mr,
    output logic [N_FULL-1:0] q_full,
    output logic [N_FULL-1:0] qn_full,
    output logic [N_HALF-1:0] q_half,
    output logic [N_HALF-1:0] qn_half
);

    logic clk_sel;
    logic en_sync;

    cgd_src_mux u_mux (
        .clk_a (clk_a),
        .clk_b (clk_b),
        .sel   (sel),
        .clk_o (clk_sel)
    );

    cgd_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_sel),
        .mr       (mr),
        .en_async (en),
        .en_sync  (en_sync)
    );

    cgd_full_bank #(.N_OUT(N_FULL)) u_full (
        .clk     (clk_sel),
        .en_sync (en_sync),
        .q       (q_full),
        .qn      (qn_full)
    );

    cgd_half_bank #(.N_OUT(N_HALF)) u_half (
        .clk     (clk_sel),
        .mr      (mr),
        .en_sync (en_sync),
        .q       (q_half),
        .qn      (qn_half)
    );

endmodule

// File: rtl/clkgate_div_fanout_chk.sv
module clkgate_div_fanout_chk #(
    parameter int unsigned N_FULL      = 2,
    parameter int unsigned N_HALF      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              mr,
    input logic              en,
    input logic              en_sync,
    input logic [N_FULL-1:0] q_full,
    input logic [N_FULL-1:0] qn_full,
    input logic [N_HALF-1:0] q_half,
    input logic [N_HALF-1:0] qn_half
);

    // R5: reset parks every output
    always @(posedge clk) begin
        if (mr) begin
            p_reset_parked_r5: assert (q_full == '0 && q_half == '0 &&
                                       qn_full == '1 && qn_half == '1);
        end
    end

    // R6: complements mirror the true outputs
    p_complement_r6: assert property (@(posedge clk) disable iff (mr)
        (qn_full == ~q_full) && (qn_half == ~q_half));

    // R2: high phase of the full bank reflects the qualified enable
    p_full_on_r2: assert property (@(negedge clk) disable iff (mr)
        en_sync |-> (q_full == '1));
    p_full_off_r2: assert property (@(negedge clk) disable iff (mr)
        !en_sync |-> (q_full == '0));

    // R2: half bank low while disabled
    p_half_off_r2: assert property (@(posedge clk) disable iff (mr)
        !en_sync |-> (q_half == '0));

    // R7: half bank alternates on every enabled rising edge
    p_half_toggle_r7: assert property (@(posedge clk) disable iff (mr)
        (en_sync && $past(en_sync)) |-> (q_half != $past(q_half)));

    // R3: qualified enable follows the raw enable two falling edges later
    if (SYNC_STAGES == 2) begin : g_lat
        p_sync_rise_r3: assert property (@(negedge clk) disable iff (mr)
            $rose(en_sync) |-> $past(en, 2));
        p_sync_fall_r3: assert property (@(negedge clk) disable iff (mr)
            $fell(en_sync) |-> !$past(en, 2));
    end

endmodule

bind clkgate_div_fanout clkgate_div_fanout_chk #(
    .N_FULL      (N_FULL),
    .N_HALF      (N_HALF),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk     (clk_sel),
    .mr      (mr),
    .en      (en),
    .en_sync (en_sync),
    .q_full  (q_full),
    .qn_full (qn_full),
    .q_half  (q_half),
    .qn_half (qn_half)
);

// File: tb/clkgate_div_fanout_tb.sv
`timescale 1ns/1ps
module clkgate_div_fanout_tb;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic sel = 1'b0;
    logic en = 1'b0;
    logic mr = 1'b0;
    logic [1:0] q_full, qn_full, q_half, qn_half;

    always #2.5 clk_a = ~clk_a;   // 200 MHz
    always #4.0 clk_b = ~clk_b;   // 125 MHz

    clkgate_div_fanout u_dut (
        .clk_a (clk_a), .clk_b (clk_b), .sel (sel), .en (en), .mr (mr),
        .q_full (q_full), .qn_full (qn_full), .q_half (q_half), .qn_half (qn_half)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // ---------------- monitors ----------------
    logic [3:0] outs;
    logic [3:0] prev = 'x;
    realtime last_t [4];
    bit have [4];
    int rise_cnt [4];
    int runt_cnt = 0;
    int inv_bad = 0;
    bit mon_on = 1'b0;

    assign outs = {q_half, q_full};

    function automatic real per();
        return sel ? 8.0 : 5.0;
    endfunction

    always @(outs) begin
        for (int i = 0; i < 4; i++) begin
            if (outs[i] !== prev[i]) begin
                if (outs[i] === 1'b1) rise_cnt[i]++;
                if (mon_on && have[i] && (($realtime - last_t[i]) < per() / 2.0 - 0.01))
                    runt_cnt++;
                last_t[i] = $realtime;
                have[i] = 1'b1;
            end
        end
        prev = outs;
    end

    initial begin
        #0.1;
        forever begin
            #0.5;
            if (mr === 1'b0 && ((qn_full !== ~q_full) || (qn_half !== ~q_half))) inv_bad++;
        end
    end

    task automatic mon_restart();
        for (int i = 0; i < 4; i++) have[i] = 1'b0;
        mon_on = 1'b1;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rise();
        if (sel) @(posedge clk_b); else @(posedge clk_a);
    endtask

    task automatic wait_fall();
        if (sel) @(negedge clk_b); else @(negedge clk_a);
    endtask

    function automatic int tenths(real v);
        return $rtoi(v * 10.0 + 0.5);
    endfunction

    task automatic check_parked(string req, string what);
        check(q_full === 2'b00 && q_half === 2'b00 && qn_full === 2'b11 && qn_half === 2'b11,
              req, what, int'({q_full, q_half}), 0);
    endtask

    task automatic measure(string tag);
        realtime t0, t1;
        int f0, f1, h0, h1;
        @(posedge q_full[0]); t0 = $realtime;
        @(posedge q_full[0]); t1 = $realtime;
        check(tenths(t1 - t0) == tenths(per()), "R1", {tag, " full period x10"},
              tenths(t1 - t0), tenths(per()));
        #1;
        f0 = rise_cnt[0] + rise_cnt[1]; h0 = rise_cnt[2] + rise_cnt[3];
        repeat (40) @(posedge q_full[0]);
        #1;
        f1 = rise_cnt[0] + rise_cnt[1]; h1 = rise_cnt[2] + rise_cnt[3];
        check(f1 - f0 == 80, "R7", {tag, " full rises (both bits)"}, f1 - f0, 80);
        check(h1 - h0 == 40, "R7", {tag, " half rises (both bits)"}, h1 - h0, 40);
        @(posedge q_half[0]); t0 = $realtime;
        @(negedge q_half[0]); t1 = $realtime;
        check(tenths(t1 - t0) == tenths(per()), "R7", {tag, " half high time x10"},
              tenths(t1 - t0), tenths(per()));
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        #0.3 mr = 1'b1;
        repeat (4) wait_rise();
        #1 check_parked("R5", "levels in reset");
        en = 1'b1;
        repeat (4) wait_rise();
        #1 check_parked("R5", "reset with enable high");
        sel = 1'b1;
        repeat (4) wait_rise();
        #1 check_parked("R5", "reset with alternate source");
        sel = 1'b0;
        repeat (3) wait_rise();

        // R8: release reset with enable high
        wait_fall(); #1.3 mr = 1'b0;
        mon_restart();
        @(posedge q_full[0]); #0.5;
        check(q_half === 2'b11 && q_full === 2'b11, "R8", "half high on first edge after reset",
              int'(q_half), 3);

        measure("src A");

        // R3: disable latency
        wait_rise(); #1 en = 1'b0;
        wait_fall(); wait_rise(); #1;
        check(q_full === 2'b11, "R3", "old state kept one more rise (disable)", int'(q_full), 3);
        wait_fall(); wait_rise(); #1;
        check(q_full === 2'b00 && q_half === 2'b00, "R2", "disabled after latency",
              int'({q_full, q_half}), 0);
        begin
            int nbad = 0;
            for (int k = 0; k < 6; k++) begin
                wait_rise(); #1;
                if (q_full !== 2'b00 || q_half !== 2'b00 || qn_full !== 2'b11 || qn_half !== 2'b11)
                    nbad++;
            end
            check(nbad == 0, "R2", "held levels while disabled", nbad, 0);
        end

        // switch source while disabled, then R3 enable latency
        sel = 1'b1;
        repeat (4) wait_rise();
        wait_rise(); #1 en = 1'b1;
        wait_fall(); wait_rise(); #1;
        check(q_full === 2'b00, "R3", "still off one rise after enable", int'(q_full), 0);
        wait_fall(); wait_rise(); #1;
        check(q_full === 2'b11 && q_half === 2'b11, "R8", "both banks high on first enabled rise",
              int'({q_full, q_half}), 15);

        measure("src B");

        // R4: enable toggled at swept phases on both sources
        for (int s = 0; s < 2; s++) begin
            wait_rise(); #1 en = 1'b0;
            repeat (4) wait_rise();
            #0.3 sel = s[0];
            repeat (4) wait_rise();
            for (int k = 0; k < 10; k++) begin
                wait_rise(); #(k * per() / 10.0 + 0.03) en = 1'b1;
                repeat (5) wait_rise();
                wait_rise(); #(k * per() / 10.0 + 0.03) en = 1'b0;
                repeat (5) wait_rise();
            end
        end
        check(runt_cnt == 0, "R4", "short pulses during phase sweep", runt_cnt, 0);
        check(rise_cnt[2] > 20 && rise_cnt[0] > 40, "R4", "sweep produced pulses",
              rise_cnt[2], 21);

        // R5: reset hits mid high phase
        en = 1'b1;
        repeat (6) wait_rise();
        wait_rise(); #1.3;
        mon_on = 1'b0;
        mr = 1'b1;
        #0.4 check_parked("R5", "immediate park on reset");
        repeat (3) wait_rise();
        #1 check_parked("R5", "parked while reset held");

        check(inv_bad == 0, "R6", "complement mismatches", inv_bad, 0);

        done = 1'b1;
        finish_run();
    end

endmodule